// File: doc/BRIEF.md
# 100BASE-X Transmit Symbol Coder

This block sits between the media-independent transmit nibble interface of a 100 Mb/s Ethernet PHY and its symbol-wide line interface. It produces one 5-bit code group per symbol clock. A frame starts when transmit enable rises. The block then replaces the first two nibble times with the start-of-stream pair, encodes each following nibble with the 4B/5B data table, and closes the stream with the end-of-stream pair. Between frames it sends idle code groups.

Each code group is XORed with five bits from an 11-bit linear feedback shift register before it leaves the block. The block also drives carrier sense and collision. For those it combines its own transmit activity with a receive-activity flag that comes from the receive path elsewhere in the PHY. A link-failure flag stops transmission at once. A strap input turns the cipher off for links that must not be scrambled.

All three outputs are registered. The inputs present at one rising clock edge decide the outputs that appear after that edge.

Top module: `tx_symbol_coder`

## Requirements
- R1: With the framer idle and no link failure, a clock edge with tx_en high emits J (11000). The next edge always emits K (10001), even if tx_en has dropped. txd and tx_er have no effect on either symbol.
- R2: After K, each edge with tx_en high and tx_er low emits the data code of txd: 0=11110, 1=01001, 2=10100, 3=10101, 4=01010, 5=01011, 6=01110, 7=01111, 8=10010, 9=10011, A=10110, B=10111, C=11010, D=11011, E=11100, F=11101.
- R3: After K, each edge with tx_en high and tx_er high emits H (00100) in place of the data code.
- R4: The first edge after K with tx_en low emits T (01101). The next edge emits R (00111). IDLE (11111) follows until tx_en is high again.
- R5: Any edge with link_fail high emits IDLE and returns the framer to idle, whatever tx_en, tx_er and the frame position are.
- R6: The cipher register is 11 bits wide and starts from a non-zero seed parameter. It steps five times on every edge after reset, in every mode. Each step forms new = bit10 XOR bit8, shifts the register left and places new in bit 0. The five new bits form the key, with the first in symbol bit 4. With cipher_off low, tx_sym is the code group XOR the key.
- R7: With cipher_off high, tx_sym is the unscrambled code group.
- R8: With full_duplex low and col_test low, col is high exactly when the emitted symbol is not IDLE and rx_active is high.
- R9: With col_test high, col follows tx_en. With full_duplex high and col_test low, col stays low.
- R10: crs is high exactly when the emitted symbol is not IDLE or rx_active is high.
- R11: Outputs change one clock after the inputs that cause them. While rst_n is low, tx_sym is 11111 and crs and col are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable from the MAC |
| tx_er | input | 1 | Transmit error from the MAC |
| txd | input | 4 | Transmit nibble, bit 0 least significant |
| link_fail | input | 1 | Link failure indication, overrides transmission |
| rx_active | input | 1 | Receive side is not idle |
| cipher_off | input | 1 | Strap: bypass the stream cipher |
| full_duplex | input | 1 | Full-duplex control bit |
| col_test | input | 1 | Collision test control bit |
| tx_sym | output | 5 | Scrambled code group to the line side |
| crs | output | 1 | Carrier sense |
| col | output | 1 | Collision |

## Verification
A wrong framer state shows on the next symbol: a missing K, a data code where T belongs, or a stream that fails to return to IDLE after link failure. The framer state also feeds carrier sense and collision, so an error there shows on crs or col in the same cycle. A cipher register that has drifted, or that is stepped the wrong number of times, corrupts every scrambled symbol from that cycle on, including the idle stream. Because of this, long idle stretches with the cipher on expose it within one clock. Bypass intervals separate framing faults from cipher faults.

// File: rtl/txc_pkg.sv
package txc_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    typedef logic [SYM_W-1:0] sym_t;

    localparam sym_t C_IDLE = 5'b11111;
    localparam sym_t C_J    = 5'b11000;
    localparam sym_t C_K    = 5'b10001;
    localparam sym_t C_T    = 5'b01101;
    localparam sym_t C_R    = 5'b00111;
    localparam sym_t C_H    = 5'b00100;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_K,
        FR_DATA,
        FR_R
    } fr_state_e;

    function automatic sym_t enc_nibble(input logic [NIB_W-1:0] n);
        sym_t s;
        unique case (n)
            4'h0: s = 5'b11110;
            4'h1: s = 5'b01001;
            4'h2: s = 5'b10100;
            4'h3: s = 5'b10101;
            4'h4: s = 5'b01010;
            4'h5: s = 5'b01011;
            4'h6: s = 5'b01110;
            4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;
            4'h9: s = 5'b10011;
            4'hA: s = 5'b10110;
            4'hB: s = 5'b10111;
            4'hC: s = 5'b11010;
            4'hD: s = 5'b11011;
            4'hE: s = 5'b11100;
            default: s = 5'b11101;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/txc_framer.sv
module txc_framer
    import txc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic [NIB_W-1:0] txd,
    input  logic             link_fail,
    output sym_t             sym_o,
    output logic             busy_o
);
    typedef struct packed {
        fr_state_e st;
    } fr_regs_t;

    fr_regs_t r_d, r_q;

    always_comb begin
        r_d   = r_q;
        sym_o = C_IDLE;
        if (link_fail) begin
            r_d.st = FR_IDLE;
        end else begin
            unique case (r_q.st)
                FR_IDLE: begin
                    if (tx_en) begin
                        sym_o  = C_J;
                        r_d.st = FR_K;
                    end
                end
                FR_K: begin
                    sym_o  = C_K;
                    r_d.st = FR_DATA;
                end
                FR_DATA: begin
                    if (tx_en) begin
                        sym_o = tx_er ? C_H : enc_nibble(txd);
                    end else begin
                        sym_o  = C_T;
                        r_d.st = FR_R;
                    end
                end
                default: begin
                    sym_o  = C_R;
                    r_d.st = FR_IDLE;
                end
            endcase
        end
        busy_o = (sym_o != C_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: FR_IDLE};
        else        r_q <= r_d;
    end

    // R5: link failure sends the framer home
    a_r5_linkfail_idle: assert property (@(posedge clk) disable iff (!rst_n)
        link_fail |=> (r_q.st == FR_IDLE));

    // R1: the symbol after J is K unless link failure intervenes
    a_r1_k_follows_j: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == FR_IDLE && tx_en && !link_fail) |=> (link_fail || sym_o == C_K));

    // R4: T is followed by R
    a_r4_r_follows_t: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == FR_DATA && !tx_en && !link_fail) |=> (link_fail || sym_o == C_R));
endmodule

// File: rtl/txc_scrambler.sv
module txc_scrambler
    import txc_pkg::*;
#(
    parameter int                LFSR_W = 11,
    parameter int                TAP    = 9,
    parameter logic [LFSR_W-1:0] SEED   = 11'h5A3
) (
    input  logic clk,
    input  logic rst_n,
    output sym_t key_o
);
    localparam int HI = LFSR_W - 1;
    localparam int LO = TAP - 1;

    typedef struct packed {
        logic [LFSR_W-1:0] lfsr;
    } cr_regs_t;

    cr_regs_t c_d, c_q;
    logic [LFSR_W-1:0] walk;

    always_comb begin
        walk  = c_q.lfsr;
        key_o = '0;
        for (int i = 0; i < SYM_W; i++) begin
            key_o[SYM_W-1-i] = walk[HI] ^ walk[LO];
            walk = {walk[LFSR_W-2:0], walk[HI] ^ walk[LO]};
        end
        c_d.lfsr = walk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{lfsr: SEED};
        else        c_q <= c_d;
    end

    // R6: the cipher register never collapses to the all-zero lockup state
    a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.lfsr != '0);
endmodule

// File: rtl/tx_symbol_coder.sv
module tx_symbol_coder
    import txc_pkg::*;
#(
    parameter int                LFSR_W = 11,
    parameter int                TAP    = 9,
    parameter logic [LFSR_W-1:0] SEED   = 11'h5A3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_en,
    input  logic       tx_er,
    input  logic [3:0] txd,
    input  logic       link_fail,
    input  logic       rx_active,
    input  logic       cipher_off,
    input  logic       full_duplex,
    input  logic       col_test,
    output logic [4:0] tx_sym,
    output logic       crs,
    output logic       col
);
    typedef struct packed {
        sym_t sym;
        logic crs;
        logic col;
    } out_regs_t;

    out_regs_t o_d, o_q;
    sym_t      plain_sym;
    sym_t      key;
    logic      tx_busy;

    txc_framer u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .tx_er     (tx_er),
        .txd       (txd),
        .link_fail (link_fail),
        .sym_o     (plain_sym),
        .busy_o    (tx_busy)
    );

    txc_scrambler #(
        .LFSR_W (LFSR_W),
        .TAP    (TAP),
        .SEED   (SEED)
    ) u_scrambler (
        .clk   (clk),
        .rst_n (rst_n),
        .key_o (key)
    );

    always_comb begin
        o_d.sym = cipher_off ? plain_sym : (plain_sym ^ key);
        o_d.crs = tx_busy | rx_active;
        o_d.col = col_test ? tx_en : (!full_duplex && tx_busy && rx_active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '{sym: C_IDLE, crs: 1'b0, col: 1'b0};
        else        o_q <= o_d;
    end

    assign tx_sym = o_q.sym;
    assign crs    = o_q.crs;
    assign col    = o_q.col;

    // R7: bypass passes the framer symbol unchanged
    a_r7_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        cipher_off |=> (tx_sym == $past(plain_sym)));

    // R9: full duplex without test keeps collision quiet
    a_r9_fd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && !col_test) |=> !col);

    // R9: collision test mirrors transmit enable
    a_r9_coltest: assert property (@(posedge clk) disable iff (!rst_n)
        col_test |=> (col == $past(tx_en)));

    // R8: half-duplex overlap raises collision
    a_r8_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && !col_test && tx_busy && rx_active) |=> col);

    // R10: receive activity alone keeps carrier sense up
    a_r10_rx_crs: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |=> crs);
endmodule

// File: tb/tx_symbol_coder_tb.sv
`timescale 1ns/1ps
module tx_symbol_coder_tb;
    localparam logic [10:0] TB_SEED = 11'h5A3;
    localparam logic [4:0] S_IDLE = 5'b11111, S_J = 5'b11000, S_K = 5'b10001,
                           S_T = 5'b01101, S_R = 5'b00111, S_H = 5'b00100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0, tx_er = 1'b0, link_fail = 1'b0, rx_active = 1'b0;
    logic       cipher_off = 1'b0, full_duplex = 1'b0, col_test = 1'b0;
    logic [3:0] txd = 4'h0;
    logic [4:0] tx_sym;
    logic       crs, col;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tx_symbol_coder #(.LFSR_W(11), .TAP(9), .SEED(TB_SEED)) u_dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_er(tx_er), .txd(txd),
        .link_fail(link_fail), .rx_active(rx_active), .cipher_off(cipher_off),
        .full_duplex(full_duplex), .col_test(col_test),
        .tx_sym(tx_sym), .crs(crs), .col(col)
    );

    function automatic logic [4:0] tb_enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    // reference model, updated on each rising edge from the inputs driven before it
    int          m_st;
    logic [10:0] m_lfsr;
    logic [4:0]  m_plain, m_key, exp_sym;
    logic        exp_crs = 1'b0, exp_col = 1'b0, m_busy, nb;
    string       sym_tag = "R11", col_tag = "R11";

    initial exp_sym = S_IDLE;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_lfsr = TB_SEED;
            exp_sym = S_IDLE; exp_crs = 1'b0; exp_col = 1'b0;
            sym_tag = "R11"; col_tag = "R11";
        end else begin
            if (link_fail) begin
                m_plain = S_IDLE; m_st = 0; sym_tag = "R5";
            end else begin
                case (m_st)
                    0: if (tx_en) begin m_plain = S_J; m_st = 1; sym_tag = "R1"; end
                       else begin m_plain = S_IDLE; sym_tag = "R4"; end
                    1: begin m_plain = S_K; m_st = 2; sym_tag = "R1"; end
                    2: if (tx_en) begin
                           m_plain = tx_er ? S_H : tb_enc(txd);
                           sym_tag = tx_er ? "R3" : "R2";
                       end else begin m_plain = S_T; m_st = 3; sym_tag = "R4"; end
                    default: begin m_plain = S_R; m_st = 0; sym_tag = "R4"; end
                endcase
            end
            for (int i = 0; i < 5; i++) begin
                nb = m_lfsr[10] ^ m_lfsr[8];
                m_key[4-i] = nb;
                m_lfsr = {m_lfsr[9:0], nb};
            end
            exp_sym = cipher_off ? m_plain : (m_plain ^ m_key);
            sym_tag = {sym_tag, cipher_off ? " R7" : " R6"};
            m_busy  = (m_plain != S_IDLE);
            exp_crs = m_busy | rx_active;
            exp_col = col_test ? tx_en : (!full_duplex && m_busy && rx_active);
            col_tag = (col_test || full_duplex) ? "R9" : "R8";
        end
    end

    task automatic check_val(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %0h exp %0h at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check_val(sym_tag, "tx_sym", int'(tx_sym), int'(exp_sym));
        check_val("R10", "crs", int'(crs), int'(exp_crs));
        check_val(col_tag, "col", int'(col), int'(exp_col));
    endtask

    task automatic send_frame(input int len, input int er_at);
        for (int i = 0; i < len; i++) begin
            tx_en = 1'b1; txd = 4'(i * 7 + 3); tx_er = (i == er_at);
            tick();
        end
        tx_en = 1'b0; tx_er = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11: reset state
        check_val("R11", "tx_sym", int'(tx_sym), 5'b11111);
        check_val("R11", "crs", int'(crs), 0);
        check_val("R11", "col", int'(col), 0);
        rst_n = 1'b1;
        repeat (3) tick();

        // directed: unscrambled frames covering J/K, data, H, T/R
        cipher_off = 1'b1;
        send_frame(20, 0);      // R1: tx_er during J not honoured
        send_frame(1, -1);      // R1: K even though tx_en dropped
        send_frame(2, 1);       // R3: error on the K slot is ignored
        send_frame(8, 5);       // R3: H in the data phase
        // R5: link failure mid-frame
        tx_en = 1'b1; repeat (5) tick();
        link_fail = 1'b1; tick(); tick();
        link_fail = 1'b0; tick(); tx_en = 1'b0; repeat (4) tick();
        // R8/R10: receive overlap in half duplex
        rx_active = 1'b1; send_frame(6, -1); rx_active = 1'b0;
        // R9: full duplex and collision test
        full_duplex = 1'b1; rx_active = 1'b1; send_frame(5, -1);
        col_test = 1'b1; send_frame(5, -1); col_test = 1'b0;
        full_duplex = 1'b0; rx_active = 1'b0;
        // R6: scrambled idle and frames
        cipher_off = 1'b0;
        repeat (20) tick();
        send_frame(16, 9);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(0, 9) == 0) tx_en = ~tx_en;
            tx_er     = ($urandom_range(0, 15) == 0);
            txd       = 4'($urandom());
            link_fail = ($urandom_range(0, 63) == 0);
            if ($urandom_range(0, 11) == 0) rx_active = ~rx_active;
            if ($urandom_range(0, 199) == 0) cipher_off = ~cipher_off;
            if ($urandom_range(0, 149) == 0) full_duplex = ~full_duplex;
            if ($urandom_range(0, 179) == 0) col_test = ~col_test;
            tick();
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule